// File: doc/BRIEF.md
# Multi-Entry Access Address Matcher

This block keeps a small table of logical radio addresses and uses it in both directions. Each entry holds two parts. One is a 24-bit base, loaded from a 32-bit register write whose upper 24 bits are kept. The other is an 8-bit prefix, which becomes the top byte of that entry's 32-bit access address.

For transmit, one index register picks the entry whose full address is driven out at all times. By convention, entry 0 carries the fixed advertising address and entry 1 carries the per-connection data address.

For receive, an external preamble detector pulses `arm`. From then on, every bit presented with `bit_valid` shifts into a 32-bit window, least significant bit first. Once at least 32 bits have arrived since arming, the window is compared on every new bit against all entries that the receive mask enables. An exact match produces a one-cycle `hit` and a held index, and the matcher disarms itself. Disabling the radio clears the armed state.

Top module: `access_addr_matcher`

## Requirements
- R1: A base write keeps `base_data[31:8]` as access address bits 23:0 of the addressed entry; `base_data[7:0]` has no effect on any output.
- R2: A prefix write places `pfx_data` in access address bits 31:24 of the addressed entry.
- R3: `tx_addr` always equals the full 32-bit address of the entry named by the transmit index register, following table and index writes from the cycle after the write.
- R4: After reset, every entry is zero, the receive mask is zero, the transmit index is 0, `armed` and `hit` are low and `hit_idx` is 0.
- R5: While not armed, received bits are ignored. A pulse on `arm` sets `armed` and discards all earlier bit history.
- R6: Bits shift in least significant bit first: the first bit after arming is address bit 0. A match needs at least 32 bits since arming and exact equality of the last 32 bits with an entry. The window slides by one bit per valid bit.
- R7: An entry whose bit in the receive mask (bit i for entry i) is 0 never produces a hit.
- R8: When several enabled entries match the same window, the lowest index is reported.
- R9: `hit` is high for exactly the one cycle after the edge that takes the completing bit. `hit_idx` is updated at the same time and then holds until the next hit. `armed` drops with the hit.
- R10: `disarm` clears `armed` at the next edge and takes priority over a simultaneous `arm`; bits after that are ignored until the next arm.
- R11: Cycles with `bit_valid` low leave the window and bit count unchanged, whatever `bit_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_idx | input | IDX_W | Entry index for base write |
| base_data | input | 32 | Base register value; bits 31:8 used |
| pfx_we | input | 1 | Prefix write strobe |
| pfx_idx | input | IDX_W | Entry index for prefix write |
| pfx_data | input | 8 | Prefix byte |
| rx_en_we | input | 1 | Receive mask write strobe |
| rx_en_data | input | N_ENTRIES | Receive mask, bit i enables entry i |
| tx_sel_we | input | 1 | Transmit index write strobe |
| tx_sel_data | input | IDX_W | Transmit entry index |
| arm | input | 1 | Pulse from the preamble detector |
| disarm | input | 1 | Radio disabled; clears armed state |
| bit_in | input | 1 | Received serial bit |
| bit_valid | input | 1 | `bit_in` carries a new bit this cycle |
| tx_addr | output | 32 | Access address of the selected transmit entry |
| armed | output | 1 | Matcher is searching |
| hit | output | 1 | One-cycle match pulse |
| hit_idx | output | IDX_W | Index of the last matched entry |

## Verification
The assertions assume that every input is at a known level from the first clock after reset. They also assume that `arm` and `disarm` are single-cycle pulses and that indices lie inside the table; with the default eight entries, every index value is legal. The bench drives inputs through tasks, one operation per cycle, a quarter period after the rising edge. Each strobe is set for exactly one cycle and then cleared, so stimulus never lands on the sampling edge. Receive patterns include interrupted words, words with a flipped bit and gaps in `bit_valid`, and all of them stay within those assumptions.

// File: rtl/aam_pkg.sv
// Package: shared widths and the address assembly rule for the matcher.
// Assumes a 32-bit access address split as 8-bit prefix over 24-bit base.
package aam_pkg;
    localparam int AA_W   = 32;
    localparam int PFX_W  = 8;
    localparam int BASE_W = AA_W - PFX_W;

    typedef logic [AA_W-1:0] aa_t;

    // Join prefix (top byte) and stored base (low 24 bits) into one address.
    function automatic aa_t join_addr(input logic [PFX_W-1:0] pfx,
                                      input logic [BASE_W-1:0] base);
        return {pfx, base};
    endfunction
endpackage

// File: rtl/aam_table.sv
// Module: address table. Holds N_ENTRIES prefix/base pairs and the transmit
// index, and drives the assembled address of every entry plus the selected
// transmit address. Assumes write indices lie inside the table.
module aam_table
    import aam_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      base_we,
    input  logic [IDX_W-1:0]          base_idx,
    input  logic [AA_W-1:0]           base_data,
    input  logic                      pfx_we,
    input  logic [IDX_W-1:0]          pfx_idx,
    input  logic [PFX_W-1:0]          pfx_data,
    input  logic                      tx_sel_we,
    input  logic [IDX_W-1:0]          tx_sel_data,
    output logic [N_ENTRIES-1:0][AA_W-1:0] entry_addr,
    output logic [AA_W-1:0]           tx_addr
);
    logic [IDX_W-1:0] tx_sel_q;
    logic [PFX_W-1:0] base_low_unused;

    // Low byte of the base write is discarded by definition.
    assign base_low_unused = base_data[PFX_W-1:0];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [BASE_W-1:0] base_q;
        logic [PFX_W-1:0]  pfx_q;

        // Store upper base bits for this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q <= '0;
            else if (base_we && base_idx == IDX_W'(g))
                base_q <= base_data[AA_W-1:PFX_W];
        end

        // Store the prefix byte for this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pfx_q <= '0;
            else if (pfx_we && pfx_idx == IDX_W'(g))
                pfx_q <= pfx_data;
        end

        assign entry_addr[g] = join_addr(pfx_q, base_q);
    end

    // Hold the transmit entry index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sel_q <= '0;
        else if (tx_sel_we)
            tx_sel_q <= tx_sel_data;
    end

    assign tx_addr = entry_addr[tx_sel_q];

    p_tx_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(base_we || pfx_we || tx_sel_we) |=> $stable(tx_addr));
endmodule

// File: rtl/aam_shifter.sv
// Module: serial window. Tracks the armed state, shifts valid bits in LSB
// first and counts them up to the address width. Presents the window as it
// will be after the current bit so the compare sees it in the same cycle.
// Assumes arm and disarm are single-cycle pulses; disarm wins over arm.
module aam_shifter
    import aam_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            disarm,
    input  logic            bit_in,
    input  logic            bit_valid,
    input  logic            found,
    output logic            armed,
    output logic [AA_W-1:0] win_next,
    output logic            check_en
);
    localparam int CW = $clog2(AA_W) + 1;

    logic [AA_W-1:0] win_q;
    logic [CW-1:0]   cnt_q;
    logic            take;

    assign take     = armed && bit_valid && !arm && !disarm;
    assign win_next = {bit_in, win_q[AA_W-1:1]};
    assign check_en = take && (cnt_q >= CW'(AA_W - 1));

    // Armed state: disarm first, then arm, then self-clear on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (disarm)
            armed <= 1'b0;
        else if (arm)
            armed <= 1'b1;
        else if (check_en && found)
            armed <= 1'b0;
    end

    // Window and bit count: cleared on arm, advanced on each taken bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (arm && !disarm) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            win_q <= win_next;
            if (cnt_q != CW'(AA_W))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !armed);
    p_arm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !disarm) |=> (armed && cnt_q == '0));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(AA_W));
endmodule

// File: rtl/aam_compare.sv
// Module: parallel comparator. Checks the window against every enabled
// entry at once and picks the lowest matching index. Purely combinational
// apart from the clock used by its checks.
module aam_compare
    import aam_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           check_en,
    input  logic [AA_W-1:0]                window,
    input  logic [N_ENTRIES-1:0][AA_W-1:0] entry_addr,
    input  logic [N_ENTRIES-1:0]           rx_mask,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               win_idx
);
    logic [N_ENTRIES-1:0] eq;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign eq[g] = check_en && rx_mask[g] && (entry_addr[g] == window);
    end

    // Lowest matching index wins: scan from the top so low indices override.
    always_comb begin
        win_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (eq[i])
                win_idx = IDX_W'(i);
        end
    end

    assign any_hit = |eq;

    p_hit_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> rx_mask[win_idx]);
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((eq & ((N_ENTRIES'(1) << win_idx) - N_ENTRIES'(1))) == '0));
endmodule

// File: rtl/access_addr_matcher.sv
// Module: top of the access address matcher. Joins the address table, the
// serial window and the comparator; owns the receive mask and the
// registered hit outputs. Assumes preamble detection happens upstream.
module access_addr_matcher
    import aam_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_we,
    input  logic [IDX_W-1:0]     base_idx,
    input  logic [31:0]          base_data,
    input  logic                 pfx_we,
    input  logic [IDX_W-1:0]     pfx_idx,
    input  logic [7:0]           pfx_data,
    input  logic                 rx_en_we,
    input  logic [N_ENTRIES-1:0] rx_en_data,
    input  logic                 tx_sel_we,
    input  logic [IDX_W-1:0]     tx_sel_data,
    input  logic                 arm,
    input  logic                 disarm,
    input  logic                 bit_in,
    input  logic                 bit_valid,
    output logic [31:0]          tx_addr,
    output logic                 armed,
    output logic                 hit,
    output logic [IDX_W-1:0]     hit_idx
);
    logic [N_ENTRIES-1:0][AA_W-1:0] entry_addr;
    logic [N_ENTRIES-1:0]           rx_mask_q;
    logic [AA_W-1:0]                win_next;
    logic                           check_en;
    logic                           any_hit;
    logic [IDX_W-1:0]               win_idx;

    aam_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_we     (base_we),
        .base_idx    (base_idx),
        .base_data   (base_data),
        .pfx_we      (pfx_we),
        .pfx_idx     (pfx_idx),
        .pfx_data    (pfx_data),
        .tx_sel_we   (tx_sel_we),
        .tx_sel_data (tx_sel_data),
        .entry_addr  (entry_addr),
        .tx_addr     (tx_addr)
    );

    aam_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .disarm    (disarm),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .found     (any_hit),
        .armed     (armed),
        .win_next  (win_next),
        .check_en  (check_en)
    );

    aam_compare #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_en   (check_en),
        .window     (win_next),
        .entry_addr (entry_addr),
        .rx_mask    (rx_mask_q),
        .any_hit    (any_hit),
        .win_idx    (win_idx)
    );

    // Receive enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_mask_q <= '0;
        else if (rx_en_we)
            rx_mask_q <= rx_en_data;
    end

    // Register the match pulse and hold the last matched index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_idx <= '0;
        end else begin
            hit <= any_hit;
            if (any_hit)
                hit_idx <= win_idx;
        end
    end

    p_hit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
    p_hit_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !armed);
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(hit_idx) || hit);
endmodule

// File: tb/tb_access_addr_matcher.sv
module tb_access_addr_matcher;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          base_we = 0, pfx_we = 0, rx_en_we = 0, tx_sel_we = 0;
    logic [IW-1:0] base_idx = 0, pfx_idx = 0, tx_sel_data = 0;
    logic [31:0]   base_data = 0;
    logic [7:0]    pfx_data = 0;
    logic [N-1:0]  rx_en_data = 0;
    logic          arm = 0, disarm = 0, bit_in = 0, bit_valid = 0;
    logic [31:0]   tx_addr;
    logic          armed, hit;
    logic [IW-1:0] hit_idx;

    access_addr_matcher #(.N_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .base_we(base_we), .base_idx(base_idx), .base_data(base_data),
        .pfx_we(pfx_we), .pfx_idx(pfx_idx), .pfx_data(pfx_data),
        .rx_en_we(rx_en_we), .rx_en_data(rx_en_data),
        .tx_sel_we(tx_sel_we), .tx_sel_data(tx_sel_data),
        .arm(arm), .disarm(disarm), .bit_in(bit_in), .bit_valid(bit_valid),
        .tx_addr(tx_addr), .armed(armed), .hit(hit), .hit_idx(hit_idx)
    );

    int checks = 0, fails = 0;
    int dut_hits = 0, cycles = 0;
    logic [IW-1:0] last_idx = 0;
    bit cmp_on = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    logic [31:0] m_base [N];
    logic [7:0]  m_pfx  [N];
    logic [N-1:0] m_mask;
    int m_tx, m_idx, m_cnt;
    bit m_armed, m_hit;
    logic [31:0] m_sh;

    function automatic logic [31:0] m_addr(input int i);
        return {m_pfx[i], m_base[i][31:8]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_base[i] = 0; m_pfx[i] = 0; end
            m_mask = 0; m_tx = 0; m_idx = 0; m_cnt = 0;
            m_armed = 0; m_hit = 0; m_sh = 0;
        end else begin
            m_hit = 0;
            if (disarm) m_armed = 0;
            else if (arm) begin m_armed = 1; m_cnt = 0; m_sh = 0; end
            else if (m_armed && bit_valid) begin
                m_sh = {bit_in, m_sh[31:1]};
                if (m_cnt < 32) m_cnt++;
                if (m_cnt == 32) begin
                    for (int i = N - 1; i >= 0; i--)
                        if (m_mask[i] && m_addr(i) == m_sh) begin m_hit = 1; m_idx = i; end
                    if (m_hit) m_armed = 0;
                end
            end
            if (base_we)   m_base[base_idx] = base_data;
            if (pfx_we)    m_pfx[pfx_idx] = pfx_data;
            if (rx_en_we)  m_mask = rx_en_data;
            if (tx_sel_we) m_tx = tx_sel_data;
        end
    end

    // Compare against the model every cycle, mid-period.
    always @(negedge clk) begin
        if (hit === 1'b1) begin dut_hits++; last_idx = hit_idx; end
        if (cmp_on) begin
            chk("R3 tx_addr vs model", tx_addr, m_addr(m_tx));
            chk("R9 hit vs model", {31'd0, hit}, {31'd0, m_hit});
            chk("R9 hit_idx vs model", {29'd0, hit_idx}, m_idx);
            chk("R10 armed vs model", {31'd0, armed}, {31'd0, m_armed});
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 50000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
        base_we = 0; pfx_we = 0; rx_en_we = 0; tx_sel_we = 0;
        arm = 0; disarm = 0; bit_valid = 0;
    endtask
    task automatic idle(input int n); repeat (n) step(); endtask
    task automatic wr_base(input int i, input logic [31:0] d);
        base_we = 1; base_idx = IW'(i); base_data = d; step();
    endtask
    task automatic wr_pfx(input int i, input logic [7:0] d);
        pfx_we = 1; pfx_idx = IW'(i); pfx_data = d; step();
    endtask
    task automatic set_entry(input int i, input logic [31:0] a);
        wr_base(i, {a[23:0], 8'hA5}); wr_pfx(i, a[31:24]);
    endtask
    task automatic wr_mask(input logic [N-1:0] m); rx_en_we = 1; rx_en_data = m; step(); endtask
    task automatic wr_tx(input int i); tx_sel_we = 1; tx_sel_data = IW'(i); step(); endtask
    task automatic do_arm(); arm = 1; step(); endtask
    task automatic do_dis(); disarm = 1; step(); endtask
    task automatic send(input logic [31:0] w, input int lo, input int hi);
        for (int k = lo; k <= hi; k++) begin bit_valid = 1; bit_in = w[k]; step(); end
    endtask
    task automatic send_gappy(input logic [31:0] w);
        for (int k = 0; k < 32; k++) begin
            bit_valid = 0; bit_in = ~w[k]; step();
            bit_valid = 1; bit_in = w[k]; step();
        end
    endtask

    localparam logic [31:0] A0 = 32'h8E89BED6;
    localparam logic [31:0] A1 = 32'h5172C3E4;
    localparam logic [31:0] AS = 32'hC0FFEE11;
    int h0;

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        cmp_on = 1;
        // R4: reset state
        chk("R4 tx_addr", tx_addr, 0);
        chk("R4 armed", {31'd0, armed}, 0);
        chk("R4 hit", {31'd0, hit}, 0);
        chk("R4 hit_idx", {29'd0, hit_idx}, 0);
        step();

        // R1 and R2: base upper bits and prefix assemble the address
        wr_base(0, 32'h89BED65A);
        idle(1);
        chk("R1 base low byte dropped", tx_addr, 32'h0089BED6);
        wr_base(0, 32'h89BED6FF);
        idle(1);
        chk("R1 low byte no effect", tx_addr, 32'h0089BED6);
        wr_pfx(0, 8'h8E);
        idle(1);
        chk("R2 prefix top byte", tx_addr, A0);

        // R3: transmit index picks the entry
        set_entry(1, A1);
        wr_tx(1);
        idle(1);
        chk("R3 tx index 1", tx_addr, A1);
        wr_tx(0);
        idle(1);
        chk("R3 tx index 0", tx_addr, A0);

        // R6/R9: plain match on entry 0, LSB first
        wr_mask(8'b0000_0001);
        do_arm();
        h0 = dut_hits;
        send(A0, 0, 31);
        idle(1);
        chk("R6 match entry 0", dut_hits - h0, 1);
        chk("R9 idx entry 0", {29'd0, last_idx}, 0);
        chk("R9 disarmed after hit", {31'd0, armed}, 0);

        // R7: disabled entry does not match
        do_arm();
        h0 = dut_hits;
        send(A1, 0, 31);
        idle(2);
        chk("R7 masked entry no hit", dut_hits - h0, 0);
        wr_mask(8'b0000_0011);
        do_arm();
        send(A1, 0, 31);
        idle(1);
        chk("R7 enabled entry hits", dut_hits - h0, 1);
        chk("R7 idx entry 1", {29'd0, last_idx}, 1);

        // R8: lowest of several matching entries
        set_entry(2, AS); set_entry(3, AS); set_entry(5, AS);
        wr_mask(8'b0010_1100);
        do_arm();
        h0 = dut_hits;
        send(AS, 0, 31);
        idle(1);
        chk("R8 lowest is 2", {29'd0, last_idx}, 2);
        wr_mask(8'b0010_1000);
        do_arm();
        send(AS, 0, 31);
        idle(1);
        chk("R8 lowest is 3", {29'd0, last_idx}, 3);
        chk("R8 two hits", dut_hits - h0, 2);

        // R5: bits before arm are ignored and arm clears history
        wr_mask(8'b0000_0001);
        h0 = dut_hits;
        send(A0, 0, 15);
        do_arm();
        send(A0, 16, 31);
        idle(2);
        chk("R5 no hit from pre-arm bits", dut_hits - h0, 0);
        chk("R5 armed after arm", {31'd0, armed}, 1);
        // R6: sliding window finds the address after leading junk
        send(A0, 0, 31);
        idle(1);
        chk("R6 sliding window hit", dut_hits - h0, 1);

        // R6: a single flipped bit never matches
        do_arm();
        h0 = dut_hits;
        send(A0 ^ 32'h0002_0000, 0, 31);
        idle(2);
        chk("R6 flipped bit no hit", dut_hits - h0, 0);

        // R11: invalid cycles carry the wrong bit and are ignored
        do_arm();
        send_gappy(A0);
        idle(1);
        chk("R11 gaps ignored", dut_hits - h0, 1);

        // R10: disarm before the last bit stops the match
        do_arm();
        h0 = dut_hits;
        send(A0, 0, 30);
        do_dis();
        chk("R10 disarmed", {31'd0, armed}, 0);
        send(A0, 31, 31);
        idle(2);
        chk("R10 no hit after disarm", dut_hits - h0, 0);
        arm = 1; disarm = 1; step();
        idle(1);
        chk("R10 disarm beats arm", {31'd0, armed}, 0);

        idle(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule